// File: doc/BRIEF.md
# Per-Pin Interrupt Condition Detector

This block watches a bank of asynchronous input pins and turns selected conditions on each pin into latched interrupt flags. Every pin is first brought into the local clock domain through a chain of flip-flops. A 4-bit condition code, programmed per pin, selects what the detector looks for on the synchronized pin: a low level, a high level, a rising edge, a falling edge, or either edge. An edge is found by comparing the current synchronized sample with the sample from the previous cycle.

Detected conditions set bits in a status register with one bit per pin. Software clears a bit by writing a 1 to it. A single interrupt output is high whenever any status bit is set, so an interrupt controller sees one request line per bank. Level conditions keep setting their flag for as long as the level holds, so a clear only sticks once the level has gone away. When a clear and a new detection arrive in the same cycle, the detection wins.

Access goes through a plain 32-bit memory-mapped port with a byte address, a write strobe and combinational read data. Each pin has a control word at byte offset 4×n, and the status word sits at byte offset 0xA0.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every control word reads zero, every status bit reads zero and `irq_o` is low.
- R2: A write to byte offset 4×n (n below `NUM_PINS`) stores bits [19:16] of the write data as the condition code of pin n. A read of that offset returns the code in bits [19:16] and zero in every other bit.
- R3: Code 0x0, and any code other than 0x8, 0x9, 0xA, 0xB or 0xC, never sets a flag, whatever the pin does.
- R4: Code 0x8 (low level) sets the pin's flag in every cycle in which its synchronized sample is 0.
- R5: Code 0xC (high level) sets the pin's flag in every cycle in which its synchronized sample is 1.
- R6: Code 0x9 (rising edge) sets the flag only when the synchronized sample is 1 and the previous sample was 0. A pin that stays high does not set the flag again after it is cleared.
- R7: Code 0xA (falling edge) sets the flag only when the synchronized sample is 0 and the previous sample was 1.
- R8: Code 0xB (either edge) sets the flag on any change of the synchronized sample.
- R9: The status word at byte offset 0xA0 holds the flag of pin n in bit n. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every flag.
- R10: When a clear and a detection hit the same bit in the same cycle, the bit stays set. A level flag therefore cannot be cleared while its level persists.
- R11: `irq_o` is high exactly when at least one status bit is set.
- R12: A pin change is seen by the detector after `SYNC_STAGES` rising clock edges. With a level code, the flag becomes visible on the next edge after that: the edge after the input changes, plus `SYNC_STAGES` more.
- R13: Reads of any other offset, including control offsets at or above pin `NUM_PINS`, return zero. Writes there change no control word and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pins being watched |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The bench builds the block with its default parameters: 32 pins, two synchronizer stages, an 8-bit byte address and a 32-bit data path. With these values both ends of the pin range, the top control offset 0x7C, the first missing pin offset 0x80 and the status offset 0xA0 can all be reached through the 8-bit address. The two-stage depth sets the exact latency that the bench checks edge by edge. A behavioural model driven by the same stimulus predicts the flags every cycle. It is compared with the status word and the interrupt line through directed cases for each code, same-cycle clear and set, and a long random mix of codes, pin toggles and partial clears.

// File: rtl/pin_irq_pkg.sv
// Package: shared condition codes and register layout for the pin
// interrupt detector. Assumes a byte-addressed 32-bit register port.
package pin_irq_pkg;

    localparam int COND_W   = 4;   // width of a condition code
    localparam int COND_LSB = 16;  // code position in a control word

    // Condition codes; the values are what software writes.
    typedef enum logic [COND_W-1:0] {
        COND_OFF  = 4'h0,
        COND_LOW  = 4'h8,
        COND_RISE = 4'h9,
        COND_FALL = 4'hA,
        COND_BOTH = 4'hB,
        COND_HIGH = 4'hC
    } cond_e;

    // Byte offset of the flag status word.
    localparam int FLAG_OFS = 32'hA0;

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings WIDTH asynchronous pins into the clock domain through STAGES
// flip-flops. It also keeps the sample from the cycle before, which the
// edge detectors compare against.
// Assumes: STAGES >= 2; every register resets to zero, so a pin that is
// high at reset is seen as a rising edge once it arrives.
module pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pins_i;
    end

    // Later stages shift the sample along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Hold the previous synchronized sample for edge compares.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign cur_o  = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/cond_detect.sv
// Module: cond_detect
// Purely combinational. Decides for each pin whether its programmed
// condition holds in this cycle, from the current and previous
// synchronized samples.
// Assumes: a code that is not one of the listed values means disabled.
module cond_detect
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0][COND_W-1:0] code_i,
    input  logic [NUM_PINS-1:0]             cur_i,
    input  logic [NUM_PINS-1:0]             prev_i,
    output logic [NUM_PINS-1:0]             hit_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise, fall;
        assign rise =  cur_i[p] & ~prev_i[p];
        assign fall = ~cur_i[p] &  prev_i[p];

        // Match this pin's code against its samples.
        always_comb begin
            unique case (code_i[p])
                COND_LOW:  hit_o[p] = ~cur_i[p];
                COND_HIGH: hit_o[p] =  cur_i[p];
                COND_RISE: hit_o[p] =  rise;
                COND_FALL: hit_o[p] =  fall;
                COND_BOTH: hit_o[p] =  rise | fall;
                default:   hit_o[p] =  1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flag_bank.sv
// Module: flag_bank
// Holds one sticky flag per pin. A hit sets a flag and a clear request
// (write one) clears it. If both reach the same bit in one cycle, the
// set wins. Also drives the combined interrupt.
// Assumes: hit_i and clr_i are synchronous to clk.
module flag_bank #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] flags_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] flags_q;

    // Update the flags: clear the requested bits, then let hits set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | hit_i;
    end

    // Combined request line.
    assign irq_o   = |flags_q;
    assign flags_o = flags_q;

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((flags_q & $past(hit_i)) == $past(hit_i)))
        else $error("hit did not set flag"); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~hit_i)) |=> ((flags_q & $past(clr_i & ~hit_i)) == '0))
        else $error("clear did not take"); // R9
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(hit_i)) == '0))
        else $error("flag rose without hit"); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(|hit_i) && !$past(|flags_q)) |-> !irq_o)
        else $error("irq without flag"); // R11

endmodule

// File: rtl/pin_irq_detector.sv
// Module: pin_irq_detector (top)
// Per-pin interrupt detector with a byte-addressed register port.
// Control word of pin n sits at byte 4*n with the code in the COND field;
// the flag status word sits at FLAG_OFS with write-one-to-clear bits.
// Assumes: NUM_PINS <= DATA_W, and the control range 4*NUM_PINS stays
// below FLAG_OFS. Read data is combinational from bus_addr.
module pin_irq_detector
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o
);

    localparam int                WORD_W  = ADDR_W - 2;
    localparam logic [WORD_W-1:0] PIN_LIM = WORD_W'(NUM_PINS);
    localparam logic [ADDR_W-1:0] FLAG_A  = ADDR_W'(FLAG_OFS);

    logic [WORD_W-1:0]               word;
    logic                            ctrl_sel, flag_sel, ctrl_we, flag_we;
    logic [NUM_PINS-1:0][COND_W-1:0] code_q;
    logic [NUM_PINS-1:0]             cur_s, prev_s, hit, clr, flags;

    // Address decode: control window or status word.
    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        ctrl_sel = (bus_addr[1:0] == 2'b00) && (word < PIN_LIM);
        flag_sel = (bus_addr == FLAG_A);
        ctrl_we  = bus_sel && bus_wr && ctrl_sel;
        flag_we  = bus_sel && bus_wr && flag_sel;
    end

    // Condition code registers, one per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[p] <= COND_OFF;
            else if (ctrl_we && word == WORD_W'(p))
                code_q[p] <= bus_wdata[COND_LSB +: COND_W];
        end
    end

    // Clear mask from a write to the status word.
    assign clr = flag_we ? bus_wdata[NUM_PINS-1:0] : '0;

    // Read-back multiplexer; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (flag_sel) begin
            bus_rdata[NUM_PINS-1:0] = flags;
        end else if (ctrl_sel) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (word == WORD_W'(p))
                    bus_rdata[COND_LSB +: COND_W] = code_q[p];
        end
    end

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .cur_o  (cur_s),
        .prev_o (prev_s)
    );

    cond_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .code_i (code_q),
        .cur_i  (cur_s),
        .prev_i (prev_s),
        .hit_o  (hit)
    );

    flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .clr_i   (clr),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    AST_CODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == '0)
        |=> (code_q[0] == $past(bus_wdata[COND_LSB +: COND_W])))
        else $error("code write lost"); // R2
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_q[0] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC}) |-> !hit[0])
        else $error("disabled pin hit"); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !(|hit)) |=> (flags == $past(flags)))
        else $error("flag changed without cause"); // R9

endmodule

// File: tb/sim_pin_irq_detector.sv
// Bench: behavioural per-cycle model compared against the register port.
module sim_pin_irq_detector;

    localparam int CLK_P = 10;
    localparam int NP    = 32;
    localparam int SYNC  = 2;

    logic        clk = 0, rst_n = 0;
    logic [31:0] pins = '0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0, fails = 0;

    // model state
    bit [31:0] m_sync [SYNC];
    bit [31:0] m_prev, m_flags;
    int        m_code [NP];

    pin_irq_detector #(.NUM_PINS(NP), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit cond_met(int code, bit cur, bit prv);
        case (code)
            8:  return !cur;
            12: return cur;
            9:  return cur && !prv;
            10: return !cur && prv;
            11: return cur != prv;
            default: return 0;
        endcase
    endfunction

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC; s++) m_sync[s] = '0;
            m_prev = '0; m_flags = '0;
            for (int p = 0; p < NP; p++) m_code[p] = 0;
        end else begin
            bit [31:0] hits, nf;
            int        a;
            a = int'(bus_addr);
            hits = '0;
            for (int p = 0; p < NP; p++)
                hits[p] = cond_met(m_code[p], m_sync[SYNC-1][p], m_prev[p]);
            nf = m_flags;
            if (bus_sel && bus_wr && a == 'hA0) nf = nf & ~bus_wdata;
            m_flags = nf | hits;
            if (bus_sel && bus_wr && a % 4 == 0 && a / 4 < NP)
                m_code[a/4] = int'(bus_wdata[19:16]);
            m_prev = m_sync[SYNC-1];
            for (int s = SYNC-1; s > 0; s--) m_sync[s] = m_sync[s-1];
            m_sync[0] = pins;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Interrupt line compared with the model on every falling edge.
    always @(negedge clk) if (rst_n) check("R11 irq", {31'b0, irq_o}, {31'b0, |m_flags});

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(string tag, int addr, logic [31:0] exp);
        bus_addr = 8'(addr); bus_sel = 1; bus_wr = 0;
        #1 check(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3); rst_n = 1; @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 0);
        rd("R1 status", 'hA0, 0);
        rd("R1 ctrl31", 'h7C, 0);

        // R2 / R3: only the code field is kept; 0xF is disabled
        wr('h0C, 32'hFFFF_FFFF);
        rd("R2 ctrl3 readback", 'h0C, 32'h000F_0000);
        repeat (4) begin pins[3] = ~pins[3]; wait_n(3); end
        rd("R3 code F quiet", 'hA0, 0);
        wr('h0C, 32'h0003_0000);
        pins[3] = 1; wait_n(4); pins[3] = 0; wait_n(4);
        rd("R3 code 3 quiet", 'hA0, 0);
        wr('h0C, 0);

        // R12 latency and R5 high level on pin 10
        wr('h28, 32'h000C_0000);
        @(negedge clk); pins[10] = 1;
        wait_n(2); rd("R12 not yet", 'hA0, 0);
        wait_n(1); rd("R12 flag visible", 'hA0, 32'h0000_0400);
        wr('hA0, 32'h0000_0400);
        rd("R10 level persists after clear", 'hA0, 32'h0000_0400);
        pins[10] = 0; wait_n(4);
        wr('hA0, 32'h0000_0400);
        rd("R5 cleared after level gone", 'hA0, 0);
        wr('h28, 0);

        // R4 low level on pin 6
        wr('h18, 32'h0008_0000);
        wait_n(1); rd("R4 low level sets", 'hA0, 32'h0000_0040);
        pins[6] = 1; wait_n(4); wr('hA0, 32'hFFFF_FFFF);
        rd("R4 clears when high", 'hA0, 0);
        wr('h18, 0);

        // R6 rising edge on pin 7
        wr('h1C, 32'h0009_0000);
        pins[7] = 1; wait_n(4);
        rd("R6 rise sets", 'hA0, 32'h0000_0080);
        wr('hA0, 32'h0000_0080); wait_n(3);
        rd("R6 steady high no reset", 'hA0, 0);
        pins[7] = 0; wait_n(4);
        rd("R6 fall ignored", 'hA0, 0);
        wr('h1C, 0);

        // R7 falling edge on pin 8
        wr('h20, 32'h000A_0000);
        pins[8] = 1; wait_n(4);
        rd("R7 rise ignored", 'hA0, 0);
        pins[8] = 0; wait_n(4);
        rd("R7 fall sets", 'hA0, 32'h0000_0100);
        wr('hA0, 32'h0000_0100);
        wr('h20, 0);

        // R8 either edge on pin 31
        wr('h7C, 32'h000B_0000);
        pins[31] = 1; wait_n(4);
        rd("R8 rise sets", 'hA0, 32'h8000_0000);
        wr('hA0, 32'h8000_0000); wait_n(1);
        rd("R8 cleared", 'hA0, 0);
        pins[31] = 0; wait_n(4);
        rd("R8 fall sets", 'hA0, 32'h8000_0000);

        // R9 zero bits leave flags alone; all ones clears
        wr('h00, 32'h0009_0000);
        pins[0] = 1; wait_n(4);
        wr('hA0, 32'h0000_0000);
        rd("R9 zero write keeps", 'hA0, 32'h8000_0001);
        wr('hA0, 32'h0000_0001);
        rd("R9 partial clear", 'hA0, 32'h8000_0000);
        wr('hA0, 32'hFFFF_FFFF);
        rd("R9 all ones clears", 'hA0, 0);

        // R13 unmapped offsets
        wr('h80, 32'h000C_0000);
        wr('h90, 32'hFFFF_FFFF);
        rd("R13 offset 80 reads zero", 'h80, 0);
        rd("R13 offset 90 reads zero", 'h90, 0);
        rd("R13 ctrl0 untouched", 'h00, 32'h0009_0000);
        rd("R13 flags untouched", 'hA0, 0);

        // R10 clear and rising detect in same cycle on pin 0
        pins[0] = 0; wait_n(4);
        wr('hA0, 32'hFFFF_FFFF);
        pins[0] = 1;             // detection lands SYNC edges later
        @(negedge clk);          // input seen by first stage at next edge
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'hA0; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        rd("R10 set wins over clear", 'hA0, 32'h0000_0001);
        wr('hA0, 32'hFFFF_FFFF);

        // Random mix compared with the model (R4-R8 together)
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                int codes[6] = '{0, 8, 9, 10, 11, 12};
                wr(4 * $urandom_range(0, NP - 1), {12'b0, 4'(codes[$urandom_range(0, 5)]), 16'b0});
            end else if (op < 6) begin
                wr('hA0, $urandom());
            end else begin
                pins = pins ^ ($urandom() & $urandom());
                @(negedge clk);
            end
            rd("R4-R8 random status", 'hA0, m_flags);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule